// File: doc/BRIEF.md
# Receive Elastic Buffer with Idle Rate Matching

This block sits after the 10B/8B decoder of one receive lane. Each decoded character enters on the lane's recovered clock together with its flags: byte value, K flag, idle flag, decoder error flag and the running disparity of an idle. The block returns the same characters on the word clock, which is the clock shared by all lanes. A small dual-clock ring absorbs phase wander between the two domains. When the two clocks differ slightly in frequency, the block keeps its fill near the centre by removing or repeating clean idle characters only, so packet contents are never touched.

The write pointer is moved back to a centred position on three events. The first is reset. The second is a pulse from the character aligner saying the framing boundary moved. The third is recognition of the opening of a lane-alignment burst, which is four idles whose disparities go d, d, not-d, not-d. A single group-sync pulse from the lane-group logic has the same effect, so several lanes can be recentred together. Recentring may lose or repeat characters. Each output character carries one prioritised 3-bit status code. A separate flag marks characters that are affected by an overrun or an underrun.

Top module: `rx_elastic_buf`

## Requirements
- R1: While reset is held and just after it is released, the output shows byte 0xBC with status code 2 (idle) and the buffer error flag low. The ring starts filled with 8 idle entries.
- R2: Every character whose status is not idle leaves the buffer exactly once, in the order it was written, with its byte unchanged. This holds as long as idles arrive often enough for the frequency offset.
- R3: The status code is 4 for a buffer error, 3 for a decoder error, 2 for idle, 1 for K and 0 for data. A higher code wins when several flags are set, so an idle that also carries a decoder error reports 3.
- R4: With freq_lock low, an incoming clean idle (idle flag high, error flag low) is not stored when the write side sees a fill of 12 or more.
- R5: With freq_lock low, a clean idle at the read head is presented again without advancing when the read side sees a fill of 4 or less.
- R6: With freq_lock high, no idle is ever deleted or repeated.
- R7: When the read side sees an empty ring, that cycle outputs status 4 with the buffer error flag high, and the read pointer holds.
- R8: When the write side sees a full ring of 16, the incoming character is dropped. The next stored character carries the buffer error flag and reports status 4 when it is read.
- R9: Four consecutive clean idles with disparities d, d, not-d, not-d cause a recentre on the fourth. That character is not stored, and the write pointer is set 10 entries ahead of the synchronised read pointer. Any other disparity pattern does not recentre.
- R10: A pulse on framing_chg or on group_sync recentres the write pointer in the same way, and the character present in that cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock of the lane (write side) |
| rd_clk | input | 1 | Word clock (read side) |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| freq_lock | input | 1 | High disables idle deletion and repetition |
| rx_byte | input | 8 | Decoded byte |
| rx_kchar | input | 1 | Character is a K character |
| rx_idle | input | 1 | Character is the idle K28.5 |
| rx_derr | input | 1 | Decoder reported a code or disparity error |
| rx_disp | input | 1 | Disparity of the idle, 1 for positive |
| framing_chg | input | 1 | Character boundary was moved (write side pulse) |
| group_sync | input | 1 | Recentre request from the lane group (write side pulse) |
| rd_byte | output | 8 | Byte out on the word clock |
| rd_status | output | 3 | Prioritised status code |
| rd_buf_err | output | 1 | Overrun or underrun affects this output |

## Verification
Deletion on the write side and repetition on the read side can both be active in the same stretch of cycles, because each side judges the fill through a lagged copy of the other pointer. Running the recovered clock 5% faster than the word clock makes the write side delete while the read side repeats near its own threshold. The reverse ratio makes the read side repeat while the write side still sees a moderate fill. In both cases the bench requires that no buffer error appears and that the scoreboard of non-idle characters drains exactly in order. Recentring on the sync pattern competes with steady drift in the same way: with the pattern the ring never overflows, and with a wrong disparity order it must overflow.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

  typedef enum logic [2:0] {
    ST_DATA = 3'd0,
    ST_KCHR = 3'd1,
    ST_IDLE = 3'd2,
    ST_DERR = 3'd3,
    ST_BERR = 3'd4
  } rx_stat_e;

  typedef struct packed {
    logic [7:0] byte_v;
    logic       kch;
    logic       idl;
    logic       derr;
    logic       berr;
  } slot_t;

  localparam logic [7:0] IDLE_BYTE = 8'hBC;
  localparam slot_t IDLE_SLOT = '{byte_v: IDLE_BYTE, kch: 1'b1, idl: 1'b1, derr: 1'b0, berr: 1'b0};

  // Highest-ranked flag decides the status code.
  function automatic rx_stat_e rank_status(input slot_t s);
    if (s.berr)      return ST_BERR;
    else if (s.derr) return ST_DERR;
    else if (s.idl)  return ST_IDLE;
    else if (s.kch)  return ST_KCHR;
    else             return ST_DATA;
  endfunction

  // A slot that rate matching may drop or repeat.
  function automatic logic is_clean_idle(input logic idl, input logic derr);
    return idl & ~derr;
  endfunction

endpackage

// File: rtl/ebuf_ptr_sync.sv
module ebuf_ptr_sync #(
  parameter int PW = 5,
  parameter int RST_BIN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  localparam logic [PW-1:0] RST_GRAY = to_gray(PW'(RST_BIN));

  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_GRAY;
      stage2 <= RST_GRAY;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = from_gray(stage2);

endmodule

// File: rtl/ebuf_sync_point.sv
module ebuf_sync_point (
  input  logic clk,
  input  logic rst_n,
  input  logic clean_idle,
  input  logic disp,
  output logic hit
);

  // index 0 is the most recent earlier character
  logic [2:0] h_ok, h_dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ok <= '0;
      h_dp <= '0;
    end else begin
      h_ok <= {h_ok[1:0], clean_idle};
      h_dp <= {h_dp[1:0], disp};
    end
  end

  assign hit = clean_idle && (&h_ok) &&
               (h_dp[2] == h_dp[1]) && (h_dp[1] != h_dp[0]) && (h_dp[0] == disp);

  a_r9_hit_needs_idles: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ($past(clean_idle) && h_ok[0] && h_ok[1]));

endmodule

// File: rtl/ebuf_wr_side.sv
module ebuf_wr_side
  import ebuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CENTER   = 8,
  parameter int DEL_AT   = 12,
  parameter int SYNC_LAG = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          flock,
  input  slot_t         in_slot,
  input  logic          recenter_req,
  input  logic [PW-1:0] rd_bin_s,
  input  logic [AW-1:0] rd_addr,
  output slot_t         head_slot,
  output logic [PW-1:0] wr_gray
);

  localparam logic [PW-1:0] RESET_W = PW'(CENTER);
  localparam logic [PW-1:0] JUMP    = PW'(CENTER + SYNC_LAG);
  localparam logic [PW-1:0] FULL_AT = PW'(DEPTH);
  localparam logic [PW-1:0] DEL_LVL = PW'(DEL_AT);

  slot_t         mem [DEPTH];
  logic [PW-1:0] wbin;
  logic          ovf_pend;

  // named events for assertions
  logic [PW-1:0] fill_w;
  logic          full_ev, del_ev, ovf_ev, we_ev;

  assign fill_w  = wbin - rd_bin_s;
  assign full_ev = (fill_w >= FULL_AT);
  assign del_ev  = !flock && !recenter_req && (fill_w >= DEL_LVL) &&
                   is_clean_idle(in_slot.idl, in_slot.derr);
  assign ovf_ev  = !recenter_req && !del_ev && full_ev;
  assign we_ev   = !recenter_req && !del_ev && !full_ev;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= RESET_W;
      wr_gray  <= RESET_W ^ (RESET_W >> 1);
      ovf_pend <= 1'b0;
    end else if (recenter_req) begin
      wbin     <= rd_bin_s + JUMP;
      wr_gray  <= (rd_bin_s + JUMP) ^ ((rd_bin_s + JUMP) >> 1);
      ovf_pend <= 1'b0;
    end else if (ovf_ev) begin
      ovf_pend <= 1'b1;
    end else if (we_ev) begin
      wbin     <= wbin + 1'b1;
      wr_gray  <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      ovf_pend <= 1'b0;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IDLE_SLOT;
    end else if (we_ev) begin
      mem[wbin[AW-1:0]] <= '{byte_v: in_slot.byte_v, kch: in_slot.kch, idl: in_slot.idl,
                             derr: in_slot.derr, berr: ovf_pend};
    end
  end

  assign head_slot = mem[rd_addr];

  a_r8_fill_bound: assert property (@(posedge wclk) disable iff (!rst_n)
    fill_w <= FULL_AT);
  a_r4_delete_holds: assert property (@(posedge wclk) disable iff (!rst_n)
    del_ev |=> $stable(wbin));
  a_r8_overrun_marks: assert property (@(posedge wclk) disable iff (!rst_n)
    ovf_ev |=> (ovf_pend && $stable(wbin)));
  a_r9_recenter_jump: assert property (@(posedge wclk) disable iff (!rst_n)
    recenter_req |=> (wbin - $past(rd_bin_s)) == JUMP);
  a_r6_no_delete_locked: assert property (@(posedge wclk) disable iff (!rst_n)
    flock |-> !del_ev);

endmodule

// File: rtl/ebuf_rd_side.sv
module ebuf_rd_side
  import ebuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DUP_AT = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          flock,
  input  logic [PW-1:0] wr_bin_s,
  input  slot_t         head_slot,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_gray,
  output logic [7:0]    out_byte,
  output rx_stat_e      out_stat,
  output logic          out_berr
);

  localparam logic [PW-1:0] FULL_AT = PW'(DEPTH);
  localparam logic [PW-1:0] DUP_LVL = PW'(DUP_AT);

  logic [PW-1:0] rbin, fill_r;
  logic          empty_ev, dup_ev;

  assign fill_r   = wr_bin_s - rbin;
  // a value above DEPTH means the read side ran past a recentred writer
  assign empty_ev = (fill_r == '0) || (fill_r > FULL_AT);
  assign dup_ev   = !flock && !empty_ev && (fill_r <= DUP_LVL) &&
                    is_clean_idle(head_slot.idl, head_slot.derr);
  assign rd_addr  = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rd_gray  <= '0;
      out_byte <= IDLE_BYTE;
      out_stat <= ST_IDLE;
      out_berr <= 1'b0;
    end else if (empty_ev) begin
      out_stat <= ST_BERR;
      out_berr <= 1'b1;
    end else begin
      out_byte <= head_slot.byte_v;
      out_stat <= rank_status(head_slot);
      out_berr <= head_slot.berr;
      if (!dup_ev) begin
        rbin    <= rbin + 1'b1;
        rd_gray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end
  end

  a_r7_underrun_flag: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_ev |=> (out_stat == ST_BERR && out_berr && $stable(rbin)));
  a_r5_repeat_holds: assert property (@(posedge rclk) disable iff (!rst_n)
    dup_ev |=> ($stable(rbin) && out_stat == ST_IDLE));
  a_r6_locked_advance: assert property (@(posedge rclk) disable iff (!rst_n)
    (flock && !empty_ev) |=> rbin == PW'($past(rbin) + 1'b1));

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import ebuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CENTER   = 8,
  parameter int DEL_AT   = 12,
  parameter int DUP_AT   = 4,
  parameter int SYNC_LAG = 2
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst_n,
  input  logic       freq_lock,
  input  logic [7:0] rx_byte,
  input  logic       rx_kchar,
  input  logic       rx_idle,
  input  logic       rx_derr,
  input  logic       rx_disp,
  input  logic       framing_chg,
  input  logic       group_sync,
  output logic [7:0] rd_byte,
  output logic [2:0] rd_status,
  output logic       rd_buf_err
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  slot_t         in_slot, head_slot;
  logic          sync_hit, recenter_req;
  logic [PW-1:0] wr_gray, rd_gray, wr_bin_s, rd_bin_s;
  logic [AW-1:0] rd_addr;
  rx_stat_e      stat;

  assign in_slot = '{byte_v: rx_byte, kch: rx_kchar, idl: rx_idle, derr: rx_derr, berr: 1'b0};

  ebuf_sync_point u_sp (
    .clk(wr_clk), .rst_n(rst_n),
    .clean_idle(is_clean_idle(rx_idle, rx_derr)), .disp(rx_disp), .hit(sync_hit)
  );

  assign recenter_req = sync_hit | framing_chg | group_sync;

  ebuf_wr_side #(.DEPTH(DEPTH), .CENTER(CENTER), .DEL_AT(DEL_AT), .SYNC_LAG(SYNC_LAG)) u_wr (
    .wclk(wr_clk), .rst_n(rst_n), .flock(freq_lock), .in_slot(in_slot),
    .recenter_req(recenter_req), .rd_bin_s(rd_bin_s), .rd_addr(rd_addr),
    .head_slot(head_slot), .wr_gray(wr_gray)
  );

  ebuf_ptr_sync #(.PW(PW), .RST_BIN(0)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_s)
  );

  ebuf_ptr_sync #(.PW(PW), .RST_BIN(CENTER)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_s)
  );

  ebuf_rd_side #(.DEPTH(DEPTH), .DUP_AT(DUP_AT)) u_rd (
    .rclk(rd_clk), .rst_n(rst_n), .flock(freq_lock), .wr_bin_s(wr_bin_s),
    .head_slot(head_slot), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .out_byte(rd_byte), .out_stat(stat), .out_berr(rd_buf_err)
  );

  assign rd_status = stat;

  a_r3_berr_top: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_buf_err |-> rd_status == 3'd4);

endmodule

// File: tb/tb_rx_elastic_buf.sv
module tb_rx_elastic_buf;
  timeunit 1ns;
  timeprecision 1ps;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic freq_lock = 1'b0;
  logic [7:0] rx_byte = 8'hBC;
  logic rx_kchar = 1'b1, rx_idle = 1'b1, rx_derr = 1'b0, rx_disp = 1'b0;
  logic framing_chg = 1'b0, group_sync = 1'b0;
  logic [7:0] rd_byte;
  logic [2:0] rd_status;
  logic rd_buf_err;

  real wper = 10.0, rper = 10.0;
  int checks = 0, fails = 0;
  int berr_cnt = 0, st4_cnt = 0;
  bit mon_on = 0, sb_on = 0;
  bit idisp = 0;
  logic [10:0] exp_q[$];

  rx_elastic_buf dut (.*);

  initial forever #(wper / 2.0) wr_clk = ~wr_clk;
  initial begin #3.0; forever #(rper / 2.0) rd_clk = ~rd_clk; end

  function automatic logic [2:0] exp_status(input logic k, input logic idl, input logic de);
    if (de) return 3'd3;
    if (idl) return 3'd2;
    if (k) return 3'd1;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge rd_clk) begin
    if (mon_on) begin
      if (rd_buf_err) berr_cnt++;
      if (rd_status == 3'd4) st4_cnt++;
      if (sb_on && rd_status != 3'd2 && rd_status != 3'd4) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected char", {rd_status, rd_byte}, 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check(rd_byte == e[7:0], "R2 byte order", rd_byte, e[7:0]);
          check(rd_status == e[10:8], "R3 status code", rd_status, e[10:8]);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input logic k, input logic idl, input logic de,
                     input logic dp, input logic fc, input logic gs);
    @(negedge wr_clk);
    rx_byte = b; rx_kchar = k; rx_idle = idl; rx_derr = de; rx_disp = dp;
    framing_chg = fc; group_sync = gs;
    if (sb_on && exp_status(k, idl, de) != 3'd2) exp_q.push_back({exp_status(k, idl, de), b});
  endtask

  task automatic put_idle();
    idisp = ~idisp;
    put(8'hBC, 1'b1, 1'b1, 1'b0, idisp, 1'b0, 1'b0);
  endtask

  task automatic put_rand(input bit allow_err);
    int r;
    r = $urandom % 16;
    if (r < 2) put(8'($urandom), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    else if (r == 2 && allow_err) put(8'($urandom), 1'($urandom), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    else put(8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic stream(input int n, input int idle_every);
    for (int i = 0; i < n; i++) begin
      if (idle_every != 0 && (i % idle_every) == 0) begin put_idle(); put_idle(); end
      else put_rand(1'b1);
    end
  endtask

  task automatic restart(input real wp, input real rp, input logic fl);
    mon_on = 0; sb_on = 0;
    rst_n = 1'b0;
    wper = wp; rper = rp; freq_lock = fl;
    repeat (4) put_idle();
    exp_q.delete();
    rst_n = 1'b1;
    repeat (3) put_idle();
    berr_cnt = 0; st4_cnt = 0;
    mon_on = 1;
  endtask

  task automatic sync_blocks(input int blocks, input bit good);
    for (int b = 0; b < blocks; b++) begin
      put(8'hBC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      put(8'hBC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      put(8'hBC, 1'b1, 1'b1, 1'b0, good ? 1'b0 : 1'b1, 1'b0, 1'b0);
      put(8'hBC, 1'b1, 1'b1, 1'b0, good ? 1'b0 : 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) put_rand(1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    // R1: reset state
    repeat (4) @(negedge wr_clk);
    @(negedge rd_clk);
    check(rd_byte == 8'hBC, "R1 reset byte", rd_byte, 8'hBC);
    check(rd_status == 3'd2, "R1 reset status", rd_status, 2);
    check(rd_buf_err == 1'b0, "R1 reset berr", rd_buf_err, 0);
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    check(rd_status == 3'd2 && !rd_buf_err, "R1 initial idles", rd_status, 2);

    // R2/R3: equal clocks, directed priority cases then random
    restart(10.0, 10.0, 1'b0);
    sb_on = 1;
    put(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    put(8'h1C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    put(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    put(8'hBC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    stream(300, 12);
    repeat (40) put_idle();
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    check(berr_cnt == 0, "R2 no buffer error", berr_cnt, 0);

    // R4: recovered clock faster, deletion needed
    restart(10.0, 10.5, 1'b0);
    sb_on = 1;
    stream(600, 10);
    repeat (60) put_idle();
    check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    check(berr_cnt == 0, "R4 no overrun", berr_cnt, 0);

    // R5: word clock faster, repetition needed
    restart(10.5, 10.0, 1'b0);
    sb_on = 1;
    stream(600, 10);
    repeat (60) put_idle();
    check(exp_q.size() == 0, "R5 drained", exp_q.size(), 0);
    check(berr_cnt == 0, "R5 no underrun", berr_cnt, 0);

    // R6/R7: locked, word clock faster, idles only -> underrun
    restart(10.5, 10.0, 1'b1);
    repeat (400) put_idle();
    check(berr_cnt > 0, "R7 R6 underrun reported", berr_cnt, 1);
    check(st4_cnt > 0, "R3 R7 status 4 on underrun", st4_cnt, 1);

    // R6/R8: locked, recovered clock faster, no idles -> overrun
    restart(10.0, 10.5, 1'b1);
    for (int i = 0; i < 400; i++) put_rand(1'b0);
    check(berr_cnt > 0, "R8 R6 overrun reported", berr_cnt, 1);

    // R9: sync pattern keeps recentring, no overrun
    restart(10.0, 10.5, 1'b1);
    sync_blocks(25, 1'b1);
    check(berr_cnt == 0, "R9 sync recentre", berr_cnt, 0);

    // R9: wrong disparity order, no recentre -> overrun
    restart(10.0, 10.5, 1'b1);
    sync_blocks(25, 1'b0);
    check(berr_cnt > 0, "R9 wrong pattern ignored", berr_cnt, 1);

    // R10: framing change and group sync pulses recentre
    restart(10.0, 10.5, 1'b1);
    for (int b = 0; b < 25; b++) begin
      put(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, (b % 2) == 0, (b % 2) == 1);
      for (int i = 0; i < 19; i++) put_rand(1'b0);
    end
    check(berr_cnt == 0, "R10 pulse recentre", berr_cnt, 0);

    mon_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule